// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command, clock-enable, byte-mask, bank and address pins of a two-bank, 16-bit single-data-rate SDRAM from the moment reset is released until the memory can accept normal traffic. It first holds the bus idle for a stabilization interval. It then closes both banks with a single all-banks precharge, loads the operating mode word and issues two auto-refresh commands. Between these steps it inserts idle cycles that cover each command's recovery time. When the last recovery time has elapsed it raises a done flag, and a downstream controller takes the bus from that point on.

A parameter decides whether the two refreshes come before or after the mode load. Every interval is given in nanoseconds. The clock period is given in picoseconds. At elaboration each interval becomes a cycle count, computed as the ceiling of interval × 1000 / period with a minimum of one cycle. The counter width follows from the largest count.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low, and afterwards until the first command, the command pins {csN,rasN,casN,weN} show idle (4'b0111), clock enable is 1, both byte masks are 1 (2'b11) and initDone is 0.
- R2: The first non-idle command appears on the pins after exactly STABLE rising edges following reset release, where STABLE = ceil(STABLE_NS*1000/CLK_PS). The byte masks stay 2'b11 and clock enable stays 1 until initDone rises.
- R3: The first command is an all-banks precharge: pins 4'b0010, address bit AP_BIT = 1, all other address bits 0, bank 0.
- R4: The mode load appears as pins 4'b0000 with bank 0. The address carries the mode word: burst-length code in bits [2:0], burst-type bit in bit 3, CAS latency in bits [6:4], and all higher bits 0.
- R5: Exactly two auto-refresh commands (pins 4'b0001) are issued. With REF_AFTER=1 the order is precharge, mode load, refresh, refresh. With REF_AFTER=0 the order is precharge, refresh, refresh, mode load.
- R6: The distance in cycles from one command to the next equals the recovery count of the earlier command. That count is precharge T_RP_NS, refresh T_RC_NS or mode load T_MRD_NS, each converted by ceiling division with a minimum of 1.
- R7: initDone rises exactly the last command's recovery count after that command. It then stays 1 until the next reset, and reset clears it.
- R8: Once initDone is 1, the pins show idle, clock enable is 1 and the byte masks are 2'b00.
- R9: A fractional conversion rounds up: with a 10000 ps clock, a 65 ns refresh time gives 7 cycles between the two refreshes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sdCke | output | 1 | Clock enable to memory |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdDqm | output | 2 | Byte masks, upper and lower |
| sdBa | output | BANK_W | Bank select |
| sdAddr | output | ADDR_W | Address bus |
| initDone | output | 1 | Initialization complete, sticky until reset |

## Verification
The assertions assume that reset is the only input besides the clock and that reset, once released, stays high for a whole sequence. They also assume the clock-period and timing parameters give recovery counts of at least one cycle. The bench therefore releases reset on a falling clock edge and leaves it high for the full stabilization wait plus the command phase. It re-asserts reset only after initDone has been observed. The bench runs two instances with different refresh placement, mode fields and a refresh time that does not divide evenly, so that ordering and rounding are both exercised.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdCmd_e;

  typedef struct packed {
    logic   issue;
    sdCmd_e cmd;
    logic   finish;
  } initStrobe_t;

  function automatic int nsToCycles(longint ns, longint ps);
    longint c;
    c = (ns * 1000 + ps - 1) / ps;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter bit REF_AFTER = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cntZero,
  output initStrobe_t strb
);

  typedef enum logic [1:0] {PH_STABLE, PH_SEQ, PH_DONE} phase_e;

  phase_e     phase;
  logic [1:0] step;
  logic [1:0] nextStep;
  sdCmd_e     seqCmd [4];

  generate
    if (REF_AFTER) begin : g_refLate
      assign seqCmd[0] = CMD_PRE;
      assign seqCmd[1] = CMD_MRS;
      assign seqCmd[2] = CMD_REF;
      assign seqCmd[3] = CMD_REF;
    end else begin : g_refEarly
      assign seqCmd[0] = CMD_PRE;
      assign seqCmd[1] = CMD_REF;
      assign seqCmd[2] = CMD_REF;
      assign seqCmd[3] = CMD_MRS;
    end
  endgenerate

  assign nextStep = (phase == PH_STABLE) ? 2'd0 : step + 2'd1;

  always_comb begin
    strb.issue  = 1'b0;
    strb.finish = 1'b0;
    strb.cmd    = CMD_NOP;
    if (cntZero) begin
      case (phase)
        PH_STABLE: begin
          strb.issue = 1'b1;
          strb.cmd   = seqCmd[nextStep];
        end
        PH_SEQ: begin
          if (step == 2'd3) begin
            strb.finish = 1'b1;
          end else begin
            strb.issue = 1'b1;
            strb.cmd   = seqCmd[nextStep];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_STABLE;
      step  <= 2'd0;
    end else if (cntZero) begin
      case (phase)
        PH_STABLE: begin
          phase <= PH_SEQ;
          step  <= 2'd0;
        end
        PH_SEQ: begin
          if (step == 2'd3) phase <= PH_DONE;
          else              step  <= nextStep;
        end
        default: ;
      endcase
    end
  end

  // R7
  done_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DONE) |=> (phase == PH_DONE && !strb.issue));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.issue, strb.finish}));

endmodule

// File: rtl/sdram_init_dp.sv
module sdram_init_dp
  import sdram_init_pkg::*;
#(
  parameter int CLK_PS    = 10000,
  parameter int STABLE_NS = 200000,
  parameter int T_RP_NS   = 20,
  parameter int T_RC_NS   = 70,
  parameter int T_MRD_NS  = 20,
  parameter int ADDR_W    = 11,
  parameter int BANK_W    = 1,
  parameter int AP_BIT    = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  initStrobe_t       strb,
  output logic              cntZero,
  output sdCmd_e            cmdQ,
  output logic              ckeQ,
  output logic [1:0]        dqmQ,
  output logic [BANK_W-1:0] baQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic              doneQ
);

  localparam int STABLE_CYC = nsToCycles(STABLE_NS, CLK_PS);
  localparam int RP_CYC     = nsToCycles(T_RP_NS, CLK_PS);
  localparam int RC_CYC     = nsToCycles(T_RC_NS, CLK_PS);
  localparam int MRD_CYC    = nsToCycles(T_MRD_NS, CLK_PS);
  localparam int MAX_A      = (RP_CYC > RC_CYC) ? RP_CYC : RC_CYC;
  localparam int MAX_B      = (MAX_A > MRD_CYC) ? MAX_A : MRD_CYC;
  localparam int MAX_CYC    = (MAX_B > STABLE_CYC) ? MAX_B : STABLE_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] STABLE_LD = CNT_W'(STABLE_CYC - 1);
  localparam logic [CNT_W-1:0] RP_LD     = CNT_W'(RP_CYC - 1);
  localparam logic [CNT_W-1:0] RC_LD     = CNT_W'(RC_CYC - 1);
  localparam logic [CNT_W-1:0] MRD_LD    = CNT_W'(MRD_CYC - 1);
  localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << AP_BIT;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;
  logic [ADDR_W-1:0] addrNext;

  assign cntZero = (cnt == '0);

  always_comb begin
    case (strb.cmd)
      CMD_PRE: loadVal = RP_LD;
      CMD_REF: loadVal = RC_LD;
      CMD_MRS: loadVal = MRD_LD;
      default: loadVal = '0;
    endcase
  end

  always_comb begin
    addrNext = '0;
    if (strb.issue && strb.cmd == CMD_PRE) addrNext = PRE_ADDR;
    if (strb.issue && strb.cmd == CMD_MRS) addrNext = MODE_WORD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= STABLE_LD;
    end else if (strb.issue) begin
      cnt <= loadVal;
    end else if (!cntZero) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ  <= CMD_NOP;
      ckeQ  <= 1'b1;
      dqmQ  <= 2'b11;
      baQ   <= '0;
      addrQ <= '0;
      doneQ <= 1'b0;
    end else begin
      cmdQ  <= strb.issue ? strb.cmd : CMD_NOP;
      ckeQ  <= 1'b1;
      dqmQ  <= (doneQ || strb.finish) ? 2'b00 : 2'b11;
      baQ   <= '0;
      addrQ <= addrNext;
      doneQ <= doneQ || strb.finish;
    end
  end

  // checking state: edges since reset, edges since last command
  logic [CNT_W-1:0] stabCnt;
  logic [CNT_W-1:0] sinceCmd;
  logic [CNT_W-1:0] needGap;
  logic             seenCmd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stabCnt  <= '0;
      sinceCmd <= '0;
      needGap  <= '0;
      seenCmd  <= 1'b0;
    end else begin
      if (stabCnt != CNT_W'(STABLE_CYC)) stabCnt <= stabCnt + 1'b1;
      if (cmdQ != CMD_NOP) begin
        sinceCmd <= CNT_W'(1);
        seenCmd  <= 1'b1;
        needGap  <= (cmdQ == CMD_PRE) ? CNT_W'(RP_CYC) :
                    (cmdQ == CMD_REF) ? CNT_W'(RC_CYC) : CNT_W'(MRD_CYC);
      end else if (sinceCmd != CNT_W'(MAX_CYC)) begin
        sinceCmd <= sinceCmd + 1'b1;
      end
    end
  end

  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !doneQ |-> (dqmQ == 2'b11 && ckeQ));

  // R2
  stable_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ != CMD_NOP) |-> (stabCnt >= CNT_W'(STABLE_CYC)));

  // R3
  first_pre_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!seenCmd && cmdQ != CMD_NOP) |-> (cmdQ == CMD_PRE && addrQ[AP_BIT]));

  // R6
  min_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seenCmd && cmdQ != CMD_NOP) |-> (sinceCmd >= needGap));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> doneQ);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (cmdQ == CMD_NOP && dqmQ == 2'b00 && ckeQ));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_PS          = 10000,
  parameter int STABLE_NS       = 200000,
  parameter int T_RP_NS         = 20,
  parameter int T_RC_NS         = 70,
  parameter int T_MRD_NS        = 20,
  parameter int ADDR_W          = 11,
  parameter int BANK_W          = 1,
  parameter int AP_BIT          = 10,
  parameter bit REF_AFTER       = 1'b1,
  parameter logic [2:0] BL_CODE = 3'd2,
  parameter bit BURST_ILV       = 1'b0,
  parameter logic [2:0] CAS_LAT = 3'd3
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [1:0]        sdDqm,
  output logic [BANK_W-1:0] sdBa,
  output logic [ADDR_W-1:0] sdAddr,
  output logic              initDone
);

  localparam logic [ADDR_W-1:0] MODE_WORD =
    ADDR_W'({CAS_LAT, BURST_ILV, BL_CODE});

  initStrobe_t strb;
  logic        cntZero;
  sdCmd_e      cmdQ;

  sdram_init_ctrl #(.REF_AFTER(REF_AFTER)) u_ctrl (
    .clk(clk), .rstN(rstN), .cntZero(cntZero), .strb(strb)
  );

  sdram_init_dp #(
    .CLK_PS(CLK_PS), .STABLE_NS(STABLE_NS), .T_RP_NS(T_RP_NS),
    .T_RC_NS(T_RC_NS), .T_MRD_NS(T_MRD_NS), .ADDR_W(ADDR_W),
    .BANK_W(BANK_W), .AP_BIT(AP_BIT), .MODE_WORD(MODE_WORD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cntZero(cntZero),
    .cmdQ(cmdQ), .ckeQ(sdCke), .dqmQ(sdDqm), .baQ(sdBa),
    .addrQ(sdAddr), .doneQ(initDone)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmdQ;

endmodule

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;

  localparam int CLK_PS = 10000;
  localparam int STAB_NS = 200000;
  localparam int RP_NS = 20;
  localparam int MRD_NS = 20;
  localparam int RC_A = 70;
  localparam int RC_B = 65;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] cke, csN, rasN, casN, weN, done;
  logic [1:0] dqm [2];
  logic [0:0] ba [2];
  logic [10:0] addr [2];

  sdram_init_seq #(.REF_AFTER(1'b1), .T_RC_NS(RC_A)) dut (
    .clk(clk), .rstN(rstN), .sdCke(cke[0]), .sdCsN(csN[0]), .sdRasN(rasN[0]),
    .sdCasN(casN[0]), .sdWeN(weN[0]), .sdDqm(dqm[0]), .sdBa(ba[0]),
    .sdAddr(addr[0]), .initDone(done[0])
  );

  sdram_init_seq #(.REF_AFTER(1'b0), .T_RC_NS(RC_B), .BL_CODE(3'd3),
                   .BURST_ILV(1'b1), .CAS_LAT(3'd2)) dut2 (
    .clk(clk), .rstN(rstN), .sdCke(cke[1]), .sdCsN(csN[1]), .sdRasN(rasN[1]),
    .sdCasN(casN[1]), .sdWeN(weN[1]), .sdDqm(dqm[1]), .sdBa(ba[1]),
    .sdAddr(addr[1]), .initDone(done[1])
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [3:0]  recCmd  [2][8];
  int          recT    [2][8];
  logic [10:0] recAddr [2][8];
  logic        recBa   [2][8];
  int nCmd [2];
  int maskViol [2];
  int postBad [2];
  int doneCyc [2];
  int doneDrop [2];

  function automatic int ceilCyc(int ns);
    int c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rstN) begin
      for (int d = 0; d < 2; d++) begin
        logic [3:0] c;
        c = {csN[d], rasN[d], casN[d], weN[d]};
        if (c != 4'b0111) begin
          if (nCmd[d] < 8) begin
            recCmd[d][nCmd[d]]  = c;
            recT[d][nCmd[d]]    = cyc;
            recAddr[d][nCmd[d]] = addr[d];
            recBa[d][nCmd[d]]   = ba[d][0];
          end
          nCmd[d]++;
        end
        if (!done[d] && (dqm[d] != 2'b11 || !cke[d])) maskViol[d]++;
        if (done[d] && doneCyc[d] < 0) doneCyc[d] = cyc;
        if (done[d] && (c != 4'b0111 || dqm[d] != 2'b00 || !cke[d])) postBad[d]++;
        if (!done[d] && doneCyc[d] >= 0) doneDrop[d]++;
      end
    end
  end

  task automatic clearRec();
    for (int d = 0; d < 2; d++) begin
      nCmd[d] = 0; maskViol[d] = 0; postBad[d] = 0;
      doneCyc[d] = -1; doneDrop[d] = 0;
    end
  endtask

  task automatic test_reset();
    rstN = 1'b0;
    clearRec();
    repeat (4) @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk("R1 idle cmd", {csN[d], rasN[d], casN[d], weN[d]}, 4'b0111);
      chk("R1 cke", cke[d], 1);
      chk("R1 dqm", dqm[d], 3);
      chk("R7 done cleared by reset", done[d], 0);
    end
    rstN = 1'b1;
  endtask

  task automatic test_early_idle();
    repeat (100) @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk("R1 no command early", nCmd[d], 0);
      chk("R1 done low early", done[d], 0);
      chk("R2 mask held early", dqm[d], 3);
    end
  endtask

  task automatic test_sequence(int d, bit refAfter, int rcNs, logic [10:0] modeExp);
    logic [3:0] expCmd [4];
    int expT [4];
    int gap;
    int stab = ceilCyc(STAB_NS);
    int rp = ceilCyc(RP_NS);
    int rc = ceilCyc(rcNs);
    int mrd = ceilCyc(MRD_NS);
    if (refAfter) begin
      expCmd[0] = 4'b0010; expCmd[1] = 4'b0000; expCmd[2] = 4'b0001; expCmd[3] = 4'b0001;
    end else begin
      expCmd[0] = 4'b0010; expCmd[1] = 4'b0001; expCmd[2] = 4'b0001; expCmd[3] = 4'b0000;
    end
    expT[0] = stab;
    for (int i = 1; i < 4; i++) begin
      gap = (expCmd[i-1] == 4'b0010) ? rp : (expCmd[i-1] == 4'b0001) ? rc : mrd;
      expT[i] = expT[i-1] + gap;
    end
    gap = (expCmd[3] == 4'b0001) ? rc : mrd;
    chk("R5 command count", nCmd[d], 4);
    chk("R2 first command cycle", recT[d][0], stab);
    chk("R3 precharge code", recCmd[d][0], 4'b0010);
    chk("R3 precharge addr", recAddr[d][0], 11'h400);
    chk("R3 precharge bank", recBa[d][0], 0);
    for (int i = 0; i < 4; i++) begin
      chk("R5 order", recCmd[d][i], expCmd[i]);
      chk("R6 command cycle", recT[d][i], expT[i]);
      if (recCmd[d][i] == 4'b0000) begin
        chk("R4 mode addr", recAddr[d][i], modeExp);
        chk("R4 mode bank", recBa[d][i], 0);
      end
    end
    chk("R7 done cycle", doneCyc[d], expT[3] + gap);
    chk("R2 masks held before done", maskViol[d], 0);
    chk("R8 idle after done", postBad[d], 0);
    chk("R7 done sticky", doneDrop[d], 0);
    chk("R8 masks low after done", dqm[d], 0);
  endtask

  task automatic test_rounding();
    int r1 = -1, r2 = -1;
    for (int i = 0; i < 4; i++)
      if (recCmd[1][i] == 4'b0001) begin
        if (r1 < 0) r1 = recT[1][i]; else r2 = recT[1][i];
      end
    chk("R9 refresh gap rounded up", r2 - r1, 7);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clearRec();
    test_reset();
    test_early_idle();
    repeat (20000) @(negedge clk);
    test_sequence(0, 1'b1, RC_A, 11'h032);
    test_sequence(1, 1'b0, RC_B, 11'h02B);
    test_rounding();
    test_reset();
    test_early_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule